// File: doc/BRIEF.md
# Cycle Counter Performance Monitor

This block measures elapsed time in clock ticks. A single 32-bit cycle counter advances on a `tick` input while it is switched on. Software reaches it through a small register bus where writes and reads each take one cycle. Software starts the count, takes snapshots by reading the live value and stops it again. It can also zero or preload the count, switch in a divide-by-64 prescale, and watch a sticky wrap flag that it clears by writing a one. Four event-slot enable bits and two auxiliary control bits are held in the registers and read back. They drive nothing inside the block.

Reads are combinational: `rd_data` shows the register selected by `addr` in the same cycle. Writes take effect at the next rising clock edge. A write that zeroes or loads the counter wins over an increment that falls in the same cycle.

Top module: `cyc_perf_mon`

## Requirements
- R1: After reset, every readable register is 0: control, enables, flags and count.
- R2: The control register is at word address 0. Bits 0 (run), 3 (divide), 4 and 5 keep the value written. Bits 1 and 2 always read 0. Bits 31:6 read 0 and ignore writes.
- R3: The count rises by 1 at each clock edge where `tick`=1, control bit 0 is 1 and enable bit 31 is 1, with divide off. In every other case the count does not change, unless a load or a reset changes it.
- R4: With control bit 3 set, the count rises once per 64 qualifying ticks. The tick prescaler restarts from 0 whenever the count is loaded or reset.
- R5: A control write with bit 1 or bit 2 set zeroes the count at that edge, and this wins over an increment. The bits take effect only once.
- R6: Writing to address 1 sets every enable bit written as 1. Writing to address 2 clears every enable bit written as 1. Both addresses read the enable state. Only bits 31 and 3:0 exist (mask 0x8000000F).
- R7: When the count wraps from 0xFFFFFFFF to 0, flag bit 31 at address 3 is set at the same edge. Writing 1 to a flag bit clears it and writing 0 leaves it alone. A wrap wins over a clear in the same cycle. Only bits 31 and 3:0 exist.
- R8: Address 4 reads the live count. A write to it loads the written value, and the load wins over an increment in the same cycle.
- R9: Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| tick | input | 1 | Count qualifier pulse |

## Verification
The bench aims at the 0xFFFFFFFF-to-0 wrap. A design that raised the flag one cycle late, or that lost it when a clear arrived in the same cycle, would show a wrong flag word. It also drives a load or a reset in the same cycle as an increment. A design that gave the increment priority would read back one count too high. In divide mode it counts exactly 63 and then 64 ticks, and it resets in the middle of a prescale period. A prescaler that was not cleared would step early. Random traffic runs over all addresses, including unmapped ones and bits outside the masks, and each readback is compared with a model in the bench.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int CTRL_RUN     = 0;
  localparam int CTRL_RST_ALL = 1;
  localparam int CTRL_RST_CYC = 2;
  localparam int CTRL_DIV     = 3;
  localparam int CTRL_W       = 6;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 6'b111001;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_ENSET = 3'd1;
  localparam logic [2:0] A_ENCLR = 3'd2;
  localparam logic [2:0] A_FLAGS = 3'd3;
  localparam logic [2:0] A_COUNT = 3'd4;

  // implemented-bit mask: top bit plus the low slot bits
  function automatic logic [31:0] f_mask(input int slots);
    logic [31:0] m;
    m = 32'h8000_0000;
    for (int i = 0; i < slots; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [32:0] f_inc(input logic [31:0] v);
    return {1'b0, v} + 33'd1;
  endfunction

  function automatic logic [31:0] f_w1s_w1c(input logic [31:0] cur,
                                            input logic [31:0] set_v,
                                            input logic [31:0] clr_v,
                                            input logic [31:0] mask);
    return ((cur | set_v) & ~clr_v) & mask;
  endfunction
endpackage

// File: rtl/cpm_prescale.sv
module cpm_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic div_on,
  output logic step
);
  logic [DIV_LOG2-1:0] presc_q;
  logic                presc_full;

  assign presc_full = (presc_q == {DIV_LOG2{1'b1}});
  assign step       = adv && (!div_on || presc_full);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) presc_q <= '0;
    else if (adv && div_on) presc_q <= presc_q + 1'b1;
  end

  // R4: the prescaler restarts from zero after a clear
  p_presc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> presc_q == '0);
endmodule

// File: rtl/cpm_cycle_cnt.sv
module cpm_cycle_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  logic [CNT_W:0] inc;

  assign inc      = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap_evt = step && !load && inc[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (step)  count <= inc[CNT_W-1:0];
  end

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> count == $past(count) + 1'b1);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> count == '0);
endmodule

// File: rtl/cpm_regs.sv
module cpm_regs
  import cpm_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_enset,
  input  logic              wr_enclr,
  input  logic              wr_flags,
  input  logic [31:0]       wd,
  input  logic              wrap_evt,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [31:0]       en_q,
  output logic [31:0]       flags_q
);
  localparam logic [31:0] MASK = f_mask(SLOTS);

  logic [31:0] en_set_v, en_clr_v, fl_clr_v, fl_set_v;

  assign en_set_v = wr_enset ? wd : '0;
  assign en_clr_v = wr_enclr ? wd : '0;
  assign fl_clr_v = wr_flags ? wd : '0;
  assign fl_set_v = {wrap_evt, 31'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      flags_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wd[CTRL_W-1:0] & CTRL_KEEP;
      en_q    <= f_w1s_w1c(en_q, en_set_v, en_clr_v, MASK);
      flags_q <= (f_w1s_w1c(flags_q, '0, fl_clr_v, MASK)) | fl_set_v;
    end
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flags_q[31]);
  p_flag_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && wd[31] && !wrap_evt) |=> !flags_q[31]);
  p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flags && flags_q[31]) |=> flags_q[31]);
endmodule

// File: rtl/cyc_perf_mon.sv
module cyc_perf_mon
  import cpm_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int DIV_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tick
);
  logic              wr_ctrl, wr_enset, wr_enclr, wr_flags, wr_count;
  logic              cnt_reset, cnt_load, adv, step, wrap_evt;
  logic [31:0]       load_val, count, en_q, flags_q;
  logic [CTRL_W-1:0] ctrl_q;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_enset = wr_en && (addr == A_ENSET);
  assign wr_enclr = wr_en && (addr == A_ENCLR);
  assign wr_flags = wr_en && (addr == A_FLAGS);
  assign wr_count = wr_en && (addr == A_COUNT);

  assign cnt_reset = wr_ctrl && (wr_data[CTRL_RST_ALL] || wr_data[CTRL_RST_CYC]);
  assign cnt_load  = cnt_reset || wr_count;
  assign load_val  = wr_count ? wr_data : '0;
  assign adv       = tick && ctrl_q[CTRL_RUN] && en_q[31];

  cpm_regs #(.SLOTS(SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_enset(wr_enset),
    .wr_enclr(wr_enclr), .wr_flags(wr_flags), .wd(wr_data),
    .wrap_evt(wrap_evt), .ctrl_q(ctrl_q), .en_q(en_q), .flags_q(flags_q)
  );

  cpm_prescale #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(cnt_load), .adv(adv),
    .div_on(ctrl_q[CTRL_DIV]), .step(step)
  );

  cpm_cycle_cnt #(.CNT_W(32)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .step(step), .count(count), .wrap_evt(wrap_evt)
  );

  always_comb begin
    case (addr)
      A_CTRL:           rd_data = {{(32-CTRL_W){1'b0}}, ctrl_q};
      A_ENSET, A_ENCLR: rd_data = en_q;
      A_FLAGS:          rd_data = flags_q;
      A_COUNT:          rd_data = count;
      default:          rd_data = '0;
    endcase
  end

  // R3: with run or cycle enable low, only a load moves the count
  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ctrl_q[CTRL_RUN] || !en_q[31]) && !cnt_load) |=> $stable(count));
  // R5: a reset write zeroes the count regardless of tick
  p_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reset |=> (count == '0) && (ctrl_q[CTRL_RST_ALL] == 1'b0) && (ctrl_q[CTRL_RST_CYC] == 1'b0));
  // R1: state right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (count == '0) && (en_q == '0) && (flags_q == '0) && (ctrl_q == '0));
endmodule

// File: tb/cyc_perf_mon_test.sv
module cyc_perf_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK = 32'h8000_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;

  logic [5:0]  m_ctrl = '0;
  logic [31:0] m_en = '0, m_flags = '0, m_count = '0;
  int          m_presc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_perf_mon uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_data(rd_data), .tick(tick));

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {26'b0, m_ctrl};
      3'd1, 3'd2: return m_en;
      3'd3: return m_flags;
      3'd4: return m_count;
      default: return 32'h0;
    endcase
  endfunction

  // model of one clock edge, written from the requirements
  task automatic model_step(input logic [2:0] a, input logic we,
                            input logic [31:0] wd, input logic tk);
    logic load, wrap;
    logic [31:0] lval;
    logic [31:0] nflags;
    wrap = 1'b0;
    load = we && ((a == 3'd0 && (wd[1] || wd[2])) || a == 3'd4);
    lval = (we && a == 3'd4) ? wd : 32'h0;
    if (load) begin
      m_count = lval; m_presc = 0;
    end else if (m_ctrl[0] && m_en[31] && tk) begin
      if (m_ctrl[3]) begin
        if (m_presc == 63) begin
          m_presc = 0; wrap = (m_count == 32'hFFFF_FFFF); m_count = m_count + 1;
        end else m_presc = m_presc + 1;
      end else begin
        wrap = (m_count == 32'hFFFF_FFFF); m_count = m_count + 1;
      end
    end
    nflags = m_flags;
    if (we && a == 3'd3) nflags = nflags & ~(wd & MASK);
    if (wrap) nflags[31] = 1'b1;
    m_flags = nflags;
    if (we && a == 3'd0) m_ctrl = wd[5:0] & 6'b111001;
    if (we && a == 3'd1) m_en = m_en | (wd & MASK);
    if (we && a == 3'd2) m_en = m_en & ~wd;
  endtask

  task automatic cyc(input logic [2:0] a, input logic we,
                     input logic [31:0] wd, input logic tk);
    @(negedge clk);
    addr = a; wr_en = we; wr_data = wd; tick = tk;
    @(posedge clk);
    model_step(a, we, wd, tk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 1'b0, 32'h0, 1'b1);
  endtask

  task automatic chk(input logic [2:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    addr = a; wr_en = 1'b0; tick = 1'b0;
    #1;
    e = exp_read(a);
    checks++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%08h expected=%08h", tag, a, rd_data, e);
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) chk(3'(a), "R1");
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) chk(3'(a), "R1");
    // R9: unmapped addresses
    cyc(3'd6, 1'b1, 32'hFFFF_FFFF, 1'b0);
    chk(3'd6, "R9"); chk(3'd7, "R9"); chk(3'd4, "R9");
    // R2: control write mask and self-clearing bits
    cyc(3'd0, 1'b1, 32'hFFFF_FFF9, 1'b0);
    chk(3'd0, "R2");
    cyc(3'd0, 1'b1, 32'h0, 1'b0);
    // R6: set/clear enables, mask
    cyc(3'd1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    chk(3'd1, "R6"); chk(3'd2, "R6");
    cyc(3'd2, 1'b1, 32'h0000_0001, 1'b0);
    chk(3'd2, "R6");
    cyc(3'd2, 1'b1, 32'h8000_0000, 1'b0);
    // R3: gating
    ticks(5); chk(3'd4, "R3");               // run off
    cyc(3'd0, 1'b1, 32'h1, 1'b0);
    ticks(5); chk(3'd4, "R3");               // cycle enable off
    cyc(3'd1, 1'b1, 32'h8000_0000, 1'b0);
    ticks(5); chk(3'd4, "R3");               // expect 5
    cyc(3'd0, 1'b0, 32'h0, 1'b0); chk(3'd4, "R3");
    // R8: load beats increment
    cyc(3'd4, 1'b1, 32'h0000_1234, 1'b1);
    chk(3'd4, "R8");
    // R7: wrap sets flag, W1C
    cyc(3'd4, 1'b1, 32'hFFFF_FFFE, 1'b0);
    ticks(2);
    chk(3'd4, "R7"); chk(3'd3, "R7");
    cyc(3'd3, 1'b1, 32'h0, 1'b0); chk(3'd3, "R7");
    cyc(3'd3, 1'b1, 32'h8000_0000, 1'b0); chk(3'd3, "R7");
    // R7: wrap wins over clear in the same cycle
    cyc(3'd4, 1'b1, 32'hFFFF_FFFF, 1'b0);
    cyc(3'd3, 1'b1, 32'h8000_0000, 1'b1); chk(3'd3, "R7");
    cyc(3'd3, 1'b1, 32'hFFFF_FFFF, 1'b0);
    // R5: reset bits beat increment, read back 0
    ticks(7);
    cyc(3'd0, 1'b1, 32'h3, 1'b1); chk(3'd4, "R5"); chk(3'd0, "R5");
    ticks(3);
    cyc(3'd0, 1'b1, 32'h5, 1'b1); chk(3'd4, "R5"); chk(3'd0, "R5");
    // R4: divide by 64
    cyc(3'd0, 1'b1, 32'h9, 1'b0);
    cyc(3'd4, 1'b1, 32'h0, 1'b0);
    ticks(63); chk(3'd4, "R4");
    ticks(1);  chk(3'd4, "R4");
    ticks(64); chk(3'd4, "R4");
    ticks(30);
    cyc(3'd0, 1'b1, 32'hD, 1'b0);            // reset mid-period, keep divide
    ticks(63); chk(3'd4, "R4");
    ticks(1);  chk(3'd4, "R4");
    // random traffic, model compare
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 19);
      d = $urandom;
      if (op < 10) cyc(3'd0, 1'b0, 32'h0, 1'($urandom_range(0, 1)));
      else if (op == 10) cyc(3'd0, 1'b1, (d & 32'hFFFF_FFF9) | 32'h1, 1'b1);
      else if (op == 11) cyc(3'd0, 1'b1, d, 1'($urandom_range(0, 1)));
      else if (op == 12) cyc(3'd1, 1'b1, d, 1'b1);
      else if (op == 13) cyc(3'd2, 1'b1, d & 32'h7FFF_FFFF, 1'b1);
      else if (op == 14) cyc(3'd3, 1'b1, d, 1'b1);
      else if (op == 15) cyc(3'd4, 1'b1, 32'hFFFF_FFF0 | (d & 32'hF), 1'b1);
      else if (op == 16) cyc(3'($urandom_range(5, 7)), 1'b1, d, 1'b1);
      else chk(3'($urandom_range(0, 7)), "R3/R4/R7/R8 random");
    end
    for (int a = 0; a < 8; a++) chk(3'(a), "R2/R6/R9 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule